// File: doc/BRIEF.md
# Effective Address Generator for ModRM/SIB Memory Operands

This block turns the operand-addressing bytes of a decoded 32-bit x86 instruction into a memory effective address. It accepts the ModRM byte, the SIB byte (used only when the ModRM encoding calls for one) and a 32-bit displacement field. It drives two read addresses into the general register file: one for the base register and one for the index register. From the two values that come back, it forms base + (index shifted by scale) + displacement. The result is registered. It appears one cycle after the request, together with the register named by the ModRM reg field.

When the mod field selects a register operand, no address is produced. The block instead reports the register named by the rm field. The encoding's special cases are resolved in a small decoder that drives the adder's enables:
- an absolute address with no base;
- a SIB byte in place of the base register;
- a "no index" code;
- a SIB form with no base.

Register numbers 0 to 7 are the register file entries EAX, ECX, EDX, EBX, ESP, EBP, ESI and EDI, in that order. Segment bases, 16-bit addressing and fault checks belong to other blocks.

Top module: `ea_gen`

## Requirements
- R1: `valid_o` is the value `valid_i` had at the previous rising clock edge, so every request yields exactly one result one cycle later. After reset, `valid_o`, `addr_o`, `is_reg_o`, `reg_o` and `rm_reg_o` are all 0.
- R2: `reg_o` equals bits [5:3] of the request's ModRM byte, unchanged, in every mod.
- R3: When mod (ModRM bits [7:6]) is 3, the result has `is_reg_o`=1, `rm_reg_o` equal to rm (ModRM bits [2:0]), and `addr_o`=0. Otherwise `is_reg_o`=0.
- R4: When mod is 0 and rm is neither 4 nor 5, the address is the value of register rm alone, and the displacement is ignored.
- R5: When mod is 1, only `disp_i[7:0]` is used. It is sign-extended to 32 bits and added.
- R6: When mod is 2, all 32 bits of `disp_i` are added.
- R7: When mod is 0 and rm is 5, the address is `disp_i`, with no register added.
- R8: When rm is 4 and mod is below 3, the SIB byte supplies scale in bits [7:6], index in bits [5:3] and base in bits [2:0]. The address is base + index×(1, 2, 4, 8 for scale 0, 1, 2, 3) + displacement.
- R9: A SIB index of 4 means that no index is added, so ESP (register 4) can serve as a base.
- R10: When mod is 0, rm is 4 and the SIB base is 5, no base register is added. The 32-bit `disp_i` is added to the scaled index.
- R11: Address arithmetic wraps modulo 2^32.
- R12: While `valid_i` is 0, `addr_o`, `is_reg_o`, `reg_o` and `rm_reg_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| modrm_i | input | 8 | ModRM byte |
| sib_i | input | 8 | SIB byte, used when rm is 4 in a memory mode |
| disp_i | input | 32 | Displacement field, with the 8-bit form in bits [7:0] |
| rf_base_addr_o | output | 3 | Register file read address for the base register |
| rf_idx_addr_o | output | 3 | Register file read address for the index register |
| rf_base_data_i | input | 32 | Register file read data for the base address |
| rf_idx_data_i | input | 32 | Register file read data for the index address |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| is_reg_o | output | 1 | Operand is a register (mod 3) |
| reg_o | output | 3 | Register named by the ModRM reg field |
| rm_reg_o | output | 3 | Register named by rm when `is_reg_o` is 1 |

## Verification
A wrong decoder enable shows up on the very next `valid_o`. A lost base or index enable changes `addr_o` by exactly one register value, because every register holds a distinct pattern. A wrong scale shift or a wrong displacement width changes it by a multiple of the index value or by the upper bytes of the displacement. Faults in the register stage show up as a `valid_o` pulse in the wrong cycle, or as `addr_o` moving while no request is present.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int FLD_W = 3;

  typedef enum logic [1:0] {
    MOD_IND = 2'd0,
    MOD_D8  = 2'd1,
    MOD_D32 = 2'd2,
    MOD_REG = 2'd3
  } mod_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_FULL = 2'd2
  } disp_e;

  localparam logic [FLD_W-1:0] RM_SIB   = 3'd4;
  localparam logic [FLD_W-1:0] RM_ABS   = 3'd5;
  localparam logic [FLD_W-1:0] IDX_NONE = 3'd4;

  typedef struct packed {
    logic       is_reg;
    logic       use_base;
    logic       use_idx;
    logic [1:0] scale;
    disp_e      disp_sel;
  } ea_ctl_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [1:0]       mod_i,
  input  logic [FLD_W-1:0] rm_i,
  input  logic [7:0]       sib_i,
  output ea_ctl_t          ctl_o,
  output logic [FLD_W-1:0] base_sel_o,
  output logic [FLD_W-1:0] idx_sel_o
);
  logic [FLD_W-1:0] sib_base, sib_idx;
  logic             has_sib;
  mod_e             mode;

  assign mode     = mod_e'(mod_i);
  assign sib_base = sib_i[2:0];
  assign sib_idx  = sib_i[5:3];
  assign has_sib  = (mode != MOD_REG) && (rm_i == RM_SIB);

  always_comb begin
    ctl_o      = '0;
    base_sel_o = '0;
    idx_sel_o  = '0;
    ctl_o.is_reg = (mode == MOD_REG);
    unique case (mode)
      MOD_D8:  ctl_o.disp_sel = DISP_B8;
      MOD_D32: ctl_o.disp_sel = DISP_FULL;
      default: ctl_o.disp_sel = DISP_NONE;
    endcase
    if (has_sib) begin
      ctl_o.scale   = sib_i[7:6];
      ctl_o.use_idx = (sib_idx != IDX_NONE);
      idx_sel_o     = ctl_o.use_idx ? sib_idx : '0;
      // mod 0 with base 5: no base, disp32 instead
      if (mode == MOD_IND && sib_base == RM_ABS) begin
        ctl_o.disp_sel = DISP_FULL;
      end else begin
        ctl_o.use_base = 1'b1;
        base_sel_o     = sib_base;
      end
    end else if (mode == MOD_IND && rm_i == RM_ABS) begin
      ctl_o.disp_sel = DISP_FULL;
    end else if (mode != MOD_REG) begin
      ctl_o.use_base = 1'b1;
      base_sel_o     = rm_i;
    end
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ea_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [ADDR_W-1:0] idx_val_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int B8_W = 8;

  logic [ADDR_W-1:0] base_term, idx_term, disp_term, disp_b8;

  generate
    if (ADDR_W > B8_W) begin : g_sext
      assign disp_b8 = {{(ADDR_W-B8_W){disp_i[B8_W-1]}}, disp_i[B8_W-1:0]};
    end else begin : g_trunc
      assign disp_b8 = disp_i;
    end
  endgenerate

  always_comb begin
    base_term = ctl_i.use_base ? base_val_i : '0;
    idx_term  = ctl_i.use_idx ? (idx_val_i << ctl_i.scale) : '0;
    unique case (ctl_i.disp_sel)
      DISP_B8:   disp_term = disp_b8;
      DISP_FULL: disp_term = disp_i;
      default:   disp_term = '0;
    endcase
    sum_o = base_term + idx_term + disp_term;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        modrm_i,
  input  logic [7:0]        sib_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [FLD_W-1:0]  rf_base_addr_o,
  output logic [FLD_W-1:0]  rf_idx_addr_o,
  input  logic [ADDR_W-1:0] rf_base_data_i,
  input  logic [ADDR_W-1:0] rf_idx_data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_reg_o,
  output logic [FLD_W-1:0]  reg_o,
  output logic [FLD_W-1:0]  rm_reg_o
);
  ea_ctl_t           ctl;
  logic [ADDR_W-1:0] sum;

  ea_decode u_dec (
    .mod_i      (modrm_i[7:6]),
    .rm_i       (modrm_i[2:0]),
    .sib_i      (sib_i),
    .ctl_o      (ctl),
    .base_sel_o (rf_base_addr_o),
    .idx_sel_o  (rf_idx_addr_o)
  );

  ea_sum #(.ADDR_W(ADDR_W)) u_sum (
    .ctl_i      (ctl),
    .base_val_i (rf_base_data_i),
    .idx_val_i  (rf_idx_data_i),
    .disp_i     (disp_i),
    .sum_o      (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      is_reg_o <= 1'b0;
      reg_o    <= '0;
      rm_reg_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o   <= ctl.is_reg ? '0 : sum;
        is_reg_o <= ctl.is_reg;
        reg_o    <= modrm_i[5:3];
        rm_reg_o <= modrm_i[2:0];
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        modrm_i,
  input logic [7:0]        sib_i,
  input logic [ADDR_W-1:0] disp_i,
  input logic [2:0]        rf_base_addr_o,
  input logic [2:0]        rf_idx_addr_o,
  input logic [ADDR_W-1:0] rf_base_data_i,
  input logic [ADDR_W-1:0] rf_idx_data_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              is_reg_o,
  input logic [2:0]        reg_o,
  input logic [2:0]        rm_reg_o
);
  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R2
  reg_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> reg_o == $past(modrm_i[5:3]));

  // R3
  reg_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_i[7:6] == 2'd3 |=> is_reg_o && addr_o == '0 && rm_reg_o == $past(modrm_i[2:0]));

  // R4
  base_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_i[7:6] != 2'd3 && modrm_i[2:0] != 3'd4 && !(modrm_i[7:6] == 2'd0 && modrm_i[2:0] == 3'd5)
      |-> rf_base_addr_o == modrm_i[2:0]);

  // R7
  absolute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_i[7:6] == 2'd0 && modrm_i[2:0] == 3'd5 |=> addr_o == $past(disp_i));

  // R9
  no_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_i[7:6] == 2'd2 && modrm_i[2:0] == 3'd4 && sib_i[5:3] == 3'd4
      |=> addr_o == $past(rf_base_data_i + disp_i));

  // R8
  index_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_i[7:6] != 2'd3 && modrm_i[2:0] == 3'd4 && sib_i[5:3] != 3'd4
      |-> rf_idx_addr_o == sib_i[5:3]);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(addr_o) && $stable(reg_o) && $stable(is_reg_o) && $stable(rm_reg_o));
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .valid_i, .modrm_i, .sib_i, .disp_i,
  .rf_base_addr_o, .rf_idx_addr_o, .rf_base_data_i, .rf_idx_data_i,
  .valid_o, .addr_o, .is_reg_o, .reg_o, .rm_reg_o
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  modrm = '0;
  logic [7:0]  sib = '0;
  logic [31:0] disp = '0;
  logic [2:0]  base_a, idx_a;
  logic [31:0] base_d, idx_d;
  logic        valid_o, is_reg;
  logic [31:0] addr;
  logic [2:0]  reg_f, rm_reg;
  logic [31:0] rf [8];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign base_d = rf[base_a];
  assign idx_d  = rf[idx_a];

  ea_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .modrm_i(modrm), .sib_i(sib),
    .disp_i(disp), .rf_base_addr_o(base_a), .rf_idx_addr_o(idx_a),
    .rf_base_data_i(base_d), .rf_idx_data_i(idx_d), .valid_o(valid_o),
    .addr_o(addr), .is_reg_o(is_reg), .reg_o(reg_f), .rm_reg_o(rm_reg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [7:0] m, logic [7:0] s, logic [31:0] d);
    logic [1:0]  md = m[7:6];
    logic [31:0] b = '0, x = '0, dv = '0;
    if (md == 2'd3) return '0;
    if (md == 2'd1) dv = {{24{d[7]}}, d[7:0]};
    if (md == 2'd2) dv = d;
    if (m[2:0] == 3'd4) begin
      if (md == 2'd0 && s[2:0] == 3'd5) dv = d;
      else b = rf[s[2:0]];
      if (s[5:3] != 3'd4) x = rf[s[5:3]] * (32'd1 << s[7:6]);
    end else if (md == 2'd0 && m[2:0] == 3'd5) dv = d;
    else b = rf[m[2:0]];
    return b + x + dv;
  endfunction

  // one request, result checked a cycle later
  task automatic issue(string req, logic [7:0] m, logic [7:0] s, logic [31:0] d);
    @(negedge clk);
    valid_i = 1'b1; modrm = m; sib = s; disp = d;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, {31'b0, valid_o}, 32'd1);
    check({req, " addr"}, addr, model(m, s, d));
    check("R2 reg field", {29'b0, reg_f}, {29'b0, m[5:3]});
    check("R3 is_reg", {31'b0, is_reg}, {31'b0, m[7:6] == 2'd3});
  endtask

  task automatic t_reset;
    check("R1 reset valid", {31'b0, valid_o}, 32'd0);
    check("R1 reset addr", addr, 32'd0);
    check("R1 reset reg", {28'b0, is_reg, reg_f}, 32'd0);
    check("R1 reset rm", {29'b0, rm_reg}, 32'd0);
  endtask

  task automatic t_reg_mode;
    for (int r = 0; r < 8; r++) begin
      issue("R3", {2'd3, 3'(7 - r), 3'(r)}, 8'hFF, 32'hDEAD_BEEF);
      check("R3 rm reg", {29'b0, rm_reg}, r);
    end
  endtask

  task automatic t_base_only;
    for (int r = 0; r < 8; r++)
      if (r != 4 && r != 5) issue("R4", {2'd0, 3'd2, 3'(r)}, 8'h00, 32'h1234_5678);
  endtask

  task automatic t_disp8;
    issue("R5 neg", 8'b01_000_011, 8'h00, 32'hFFFF_FF80);
    issue("R5 pos", 8'b01_001_110, 8'h00, 32'hABCD_EF7F);
    issue("R5 ebp", 8'b01_001_101, 8'h00, 32'h0000_00FF);
    check("R5 ebp value", addr, rf[5] - 32'd1);
  endtask

  task automatic t_disp32;
    issue("R6", 8'b10_000_001, 8'h00, 32'h8000_0010);
    issue("R6 ebp", 8'b10_111_101, 8'h00, 32'h0001_0000);
  endtask

  task automatic t_abs;
    issue("R7", 8'b00_011_101, 8'h00, 32'hCAFE_0000);
    check("R7 value", addr, 32'hCAFE_0000);
  endtask

  task automatic t_sib;
    for (int sc = 0; sc < 4; sc++) begin
      issue("R8", 8'b01_000_100, {2'(sc), 3'd6, 3'd3}, 32'h0000_0004);
      check("R8 scale value", addr, rf[3] + (rf[6] << sc) + 32'd4);
    end
    issue("R8 mod0", 8'b00_000_100, {2'd3, 3'd1, 3'd7}, 32'hFFFF_FFFF);
    check("R8 mod0 no disp", addr, rf[7] + (rf[1] << 3));
  endtask

  task automatic t_no_index;
    issue("R9 esp base", 8'b00_000_100, {2'd3, 3'd4, 3'd4}, 32'h0);
    check("R9 value", addr, rf[4]);
    issue("R9 disp8", 8'b01_000_100, {2'd2, 3'd4, 3'd0}, 32'h0000_0010);
  endtask

  task automatic t_sib_nobase;
    issue("R10", 8'b00_000_100, {2'd2, 3'd2, 3'd5}, 32'h0040_0000);
    check("R10 value", addr, (rf[2] << 2) + 32'h0040_0000);
    issue("R10 mod1 keeps base", 8'b01_000_100, {2'd0, 3'd4, 3'd5}, 32'h0000_0001);
    check("R10 mod1 value", addr, rf[5] + 32'd1);
  endtask

  task automatic t_wrap;
    issue("R11", 8'b10_000_100, {2'd3, 3'd7, 3'd3}, 32'h0000_0100);
    check("R11 value", addr, rf[3] + (rf[7] << 3) + 32'h100);
    issue("R11 base", 8'b01_000_011, 8'h00, 32'h0000_0020);
    check("R11 base value", addr, 32'h0000_0010);
  endtask

  task automatic t_hold;
    logic [31:0] a0;
    issue("R12 setup", 8'b10_101_010, 8'h00, 32'h55);
    a0 = addr;
    @(negedge clk);
    modrm = 8'b11_000_001; disp = 32'h9999_9999; sib = 8'h1B;
    @(negedge clk);
    check("R12 valid low", {31'b0, valid_o}, 32'd0);
    check("R12 addr held", addr, a0);
    check("R12 reg held", {28'b0, is_reg, reg_f}, {28'b0, 1'b0, 3'd5});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h0101_0000 * (i + 1) + 32'h0000_0333 * (i + 1);
    rf[3] = 32'hFFFF_FFF0;
    rf[7] = 32'h3000_0001;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reg_mode;
    t_base_only;
    t_disp8;
    t_disp32;
    t_abs;
    t_sib;
    t_no_index;
    t_sib_nobase;
    t_wrap;
    t_hold;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule